// File: doc/BRIEF.md
# Early Control-Flag Serial Stream Generator

This block produces one serial control line that carries one flag per output channel per frame: 8 streams × 32 channels = 256 flags. Each flag is bit 1 of a per-channel control word kept in an external connection-control memory. The line runs one full channel ahead of the data streams, so that external switching circuits have a whole channel time to act on a flag before its data channel starts. Within one channel time, the eight bit cells carry the flags of the eight streams for the next channel, in transposed order.

A frame counter outside the block supplies a one-clock `cell_tick` at each bit-cell boundary, together with the channel and cell index of the cell that starts on that edge. On every tick the block sends one read to the memory. Over one channel it collects the eight flags needed for the channel after next into a staging register. At the next channel boundary it moves them into an output shift register. The read therefore never sits in the path to the output.

When the timing is broken, the block sends zeros instead of stale or misplaced flags. This covers a start after reset, a frame realignment that jumps to another channel, and cells that arrive out of order. Correct flags resume once a full, in-order channel of fetches has completed.

Top module: `ctl_flag_serializer`

## Requirements
- R1: While `rst_n` is low, `ctl_out` is 0 and `rd_en` is 0. Reset asserts asynchronously and is released inside the block two clocks after `rst_n` rises.
- R2: The flag is bit 1 of the 8-bit control word. Bits 7..2 and bit 0 have no effect on `ctl_out`.
- R3: The cells of channel c carry the flags of channel (c+1) mod 32, so channel 31 carries the flags of channel 0 of the next frame.
- R4: Within a channel, the cell with `cell_num` = k (k = 0 first, up to 7) carries the flag of stream k.
- R5: `ctl_out` changes only on a clock edge at which `cell_tick` is sampled high. The value it takes is the flag for the cell named by `chan_num`/`cell_num` on that edge. Between ticks the output holds.
- R6: Out of reset, `rd_en` equals `cell_tick`. On each request, `rd_addr` = `cell_num`×32 + ((`chan_num`+2) mod 32), which means stream in bits 7..5 and channel in bits 4..0.
- R7: The memory answers one clock after the request. The block samples `rd_data` on the edge that follows the edge on which it issued `rd_en`.
- R8: A flag is taken from memory as it stands at its fetch, which is tick k of channel c−1 for the flag sent in cell k of channel c. A change written after that fetch shows one frame later.
- R9: On a cell-0 tick of channel c, the prefetched flags are used only if the eight preceding ticks were cells 0..7 of channel c−1, in order. Otherwise `ctl_out` is 0 for the whole of channel c.
- R10: A tick with `cell_num` ≠ 0 that does not follow cell `cell_num`−1 of the same channel forces `ctl_out` to 0 for the rest of that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; two clocks or more per bit cell |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cell_tick | input | 1 | One-clock pulse at each bit-cell boundary, never on two adjacent clocks |
| chan_num | input | 5 | Data channel of the cell starting on this tick |
| cell_num | input | 3 | Bit-cell index within the channel, 0 first |
| rd_en | output | 1 | Read request to the control memory |
| rd_addr | output | 8 | Read address: stream in bits 7..5, channel in bits 4..0 |
| rd_data | input | 8 | Control word returned one clock after the request |
| ctl_out | output | 1 | Serial control flag output |

## Verification
The hardest case to reach is a prefetch that completed for one channel while the timing has since moved to a different one. In that case the stored flags are complete and look valid, but they belong to the wrong place. The stimulus produces this in several ways:
- It realigns the frame to a distant channel.
- It drops cells in the middle of a channel.
- It repeats a cell-0 tick.
- It resumes right after a reset, and crosses the channel 31 to channel 0 wrap.

The bench model decides validity only from the history of ticks, and it samples memory at each tick's edge. This lets it also catch a word that was rewritten between its fetch and its use.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int unsigned CSB_STREAMS  = 8;
  localparam int unsigned CSB_CHANS    = 32;
  localparam int unsigned CSB_WORD_W   = 8;
  localparam int unsigned CSB_FLAG_POS = 1;
  localparam int unsigned CSB_LEAD     = 1;

  // modular channel arithmetic for the lead / prefetch offsets
  function automatic int unsigned csb_wrap(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned modulus);
    return (base + step) % modulus;
  endfunction
endpackage

// File: rtl/csb_slot_track.sv
module csb_slot_track #(
  parameter int unsigned CH_W = 5,
  parameter int unsigned ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cell_tick,
  input  logic [CH_W-1:0] chan_num,
  input  logic [ST_W-1:0] cell_num,
  output logic            start_tick,
  output logic            seq_tick,
  output logic            break_tick
);
  logic [CH_W-1:0] last_chan_q, last_chan_d;
  logic [ST_W-1:0] last_cell_q, last_cell_d;
  logic            last_vld_q, last_vld_d;
  logic            trk_en, in_seq;

  always_comb begin
    in_seq = last_vld_q && (chan_num == last_chan_q) &&
             ({1'b0, cell_num} == ({1'b0, last_cell_q} + (ST_W+1)'(1)));
    start_tick = cell_tick && (cell_num == '0);
    seq_tick   = cell_tick && (cell_num != '0) && in_seq;
    break_tick = cell_tick && (cell_num != '0) && !in_seq;
    trk_en      = cell_tick;
    last_chan_d = chan_num;
    last_cell_d = cell_num;
    last_vld_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_chan_q <= '0;
      last_cell_q <= '0;
      last_vld_q  <= 1'b0;
    end else if (trk_en) begin
      last_chan_q <= last_chan_d;
      last_cell_q <= last_cell_d;
      last_vld_q  <= last_vld_d;
    end
  end
endmodule

// File: rtl/csb_flag_fetch.sv
module csb_flag_fetch
  import csb_pkg::*;
#(
  parameter int unsigned NS       = CSB_STREAMS,
  parameter int unsigned NCH      = CSB_CHANS,
  parameter int unsigned WORD_W   = CSB_WORD_W,
  parameter int unsigned FLAG_POS = CSB_FLAG_POS,
  parameter int unsigned LEAD     = CSB_LEAD,
  localparam int unsigned ST_W    = $clog2(NS),
  localparam int unsigned CH_W    = $clog2(NCH),
  localparam int unsigned ADDR_W  = $clog2(NS*NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_tick,
  input  logic [CH_W-1:0]   chan_num,
  input  logic [ST_W-1:0]   cell_num,
  input  logic              start_tick,
  input  logic              seq_tick,
  input  logic              break_tick,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [NS-1:0]     stage_bits,
  output logic              stage_full,
  output logic [CH_W-1:0]   stage_chan
);
  logic [CH_W-1:0] fetch_chan;
  logic            run_q, run_d;
  logic            pend_vld_q, pend_vld_d;
  logic            pend_ok_q, pend_ok_d;
  logic [ST_W-1:0] pend_cell_q, pend_cell_d;
  logic [CH_W-1:0] pend_chan_q, pend_chan_d;
  logic            pend_en;
  logic            full_q, full_d;
  logic [CH_W-1:0] schan_q, schan_d;
  logic            done, cap_bit;
  logic [NS-1:0]   stage_q, cap_en;

  always_comb begin
    fetch_chan = CH_W'(csb_wrap(32'(chan_num), LEAD + 1, NCH));
    rd_en      = cell_tick && rst_n;
    rd_addr    = ADDR_W'(32'(cell_num) * NCH + 32'(fetch_chan));
    cap_bit    = rd_data[FLAG_POS];
    done       = pend_vld_q && pend_ok_q && (pend_cell_q == ST_W'(NS-1));

    run_d = run_q;
    if (start_tick)      run_d = 1'b1;
    else if (break_tick) run_d = 1'b0;

    pend_vld_d  = cell_tick;
    pend_en     = cell_tick;
    pend_ok_d   = start_tick || (seq_tick && run_q);
    pend_cell_d = cell_num;
    pend_chan_d = fetch_chan;

    full_d = full_q;
    if (start_tick || break_tick) full_d = 1'b0;
    else if (done)                full_d = 1'b1;
    schan_d = pend_chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      pend_vld_q  <= 1'b0;
      pend_ok_q   <= 1'b0;
      pend_cell_q <= '0;
      pend_chan_q <= '0;
      full_q      <= 1'b0;
      schan_q     <= '0;
    end else begin
      run_q      <= run_d;
      pend_vld_q <= pend_vld_d;
      full_q     <= full_d;
      if (pend_en) begin
        pend_ok_q   <= pend_ok_d;
        pend_cell_q <= pend_cell_d;
        pend_chan_q <= pend_chan_d;
      end
      if (done) schan_q <= schan_d;
    end
  end

  // one capture flop per stream, written when that stream's word returns
  for (genvar gi = 0; gi < NS; gi++) begin : g_cap
    assign cap_en[gi] = pend_vld_q && (pend_cell_q == ST_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stage_q[gi] <= 1'b0;
      else if (cap_en[gi]) stage_q[gi] <= cap_bit;
    end
  end

  assign stage_bits = stage_q;
  assign stage_full = full_q;
  assign stage_chan = schan_q;
endmodule

// File: rtl/csb_shift_out.sv
module csb_shift_out
  import csb_pkg::*;
#(
  parameter int unsigned NS   = CSB_STREAMS,
  parameter int unsigned NCH  = CSB_CHANS,
  parameter int unsigned LEAD = CSB_LEAD,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cell_tick,
  input  logic            start_tick,
  input  logic            seq_tick,
  input  logic [CH_W-1:0] chan_num,
  input  logic [NS-1:0]   stage_bits,
  input  logic            stage_full,
  input  logic [CH_W-1:0] stage_chan,
  output logic            ctl_out
);
  logic [NS-1:0]   act_q, act_d;
  logic            ok_q, ok_d;
  logic            out_q, out_d;
  logic            sh_en, use_stage;
  logic [CH_W-1:0] want_chan;

  always_comb begin
    want_chan = CH_W'(csb_wrap(32'(chan_num), LEAD, NCH));
    use_stage = stage_full && (stage_chan == want_chan);
    sh_en = cell_tick;
    act_d = act_q;
    ok_d  = ok_q;
    out_d = out_q;
    if (start_tick) begin
      out_d = use_stage & stage_bits[0];
      act_d = stage_bits >> 1;
      ok_d  = use_stage;
    end else begin
      ok_d  = ok_q & seq_tick;
      out_d = ok_d & act_q[0];
      act_d = act_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      ok_q  <= 1'b0;
      out_q <= 1'b0;
    end else if (sh_en) begin
      act_q <= act_d;
      ok_q  <= ok_d;
      out_q <= out_d;
    end
  end

  assign ctl_out = out_q;
endmodule

// File: rtl/ctl_flag_serializer.sv
module ctl_flag_serializer
  import csb_pkg::*;
#(
  parameter int unsigned NS       = CSB_STREAMS,
  parameter int unsigned NCH      = CSB_CHANS,
  parameter int unsigned WORD_W   = CSB_WORD_W,
  parameter int unsigned FLAG_POS = CSB_FLAG_POS,
  parameter int unsigned LEAD     = CSB_LEAD,
  localparam int unsigned ST_W    = $clog2(NS),
  localparam int unsigned CH_W    = $clog2(NCH),
  localparam int unsigned ADDR_W  = $clog2(NS*NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_tick,
  input  logic [CH_W-1:0]   chan_num,
  input  logic [ST_W-1:0]   cell_num,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              ctl_out
);
  logic [1:0]      rs_q;
  logic            core_rst_n;
  logic            start_tick, seq_tick, break_tick;
  logic [NS-1:0]   stage_bits;
  logic            stage_full;
  logic [CH_W-1:0] stage_chan;

  // asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  csb_slot_track #(.CH_W(CH_W), .ST_W(ST_W)) u_track (
    .clk(clk), .rst_n(core_rst_n), .cell_tick(cell_tick),
    .chan_num(chan_num), .cell_num(cell_num),
    .start_tick(start_tick), .seq_tick(seq_tick), .break_tick(break_tick)
  );

  csb_flag_fetch #(.NS(NS), .NCH(NCH), .WORD_W(WORD_W), .FLAG_POS(FLAG_POS),
                   .LEAD(LEAD)) u_fetch (
    .clk(clk), .rst_n(core_rst_n), .cell_tick(cell_tick),
    .chan_num(chan_num), .cell_num(cell_num),
    .start_tick(start_tick), .seq_tick(seq_tick), .break_tick(break_tick),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .stage_bits(stage_bits), .stage_full(stage_full), .stage_chan(stage_chan)
  );

  csb_shift_out #(.NS(NS), .NCH(NCH), .LEAD(LEAD)) u_shift (
    .clk(clk), .rst_n(core_rst_n), .cell_tick(cell_tick),
    .start_tick(start_tick), .seq_tick(seq_tick), .chan_num(chan_num),
    .stage_bits(stage_bits), .stage_full(stage_full), .stage_chan(stage_chan),
    .ctl_out(ctl_out)
  );
endmodule

// File: rtl/csb_checker.sv
module csb_checker
  import csb_pkg::*;
#(
  parameter int unsigned NS  = CSB_STREAMS,
  parameter int unsigned NCH = CSB_CHANS,
  localparam int unsigned ST_W = $clog2(NS),
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cell_tick,
  input logic [CH_W-1:0] chan_num,
  input logic [ST_W-1:0] cell_num,
  input logic            ctl_out
);
  logic [CH_W-1:0] lc_q;
  logic [ST_W-1:0] lcell_q;
  logic            lv_q, run_ok_q;
  logic            ck_inseq, ck_break, ck_start, ck_prev_ok;

  always_comb begin
    ck_start = cell_tick && (cell_num == '0);
    ck_inseq = lv_q && (chan_num == lc_q) &&
               (32'(cell_num) == 32'(lcell_q) + 1);
    ck_break = cell_tick && (cell_num != '0) && !ck_inseq;
    ck_prev_ok = lv_q && run_ok_q && (32'(lcell_q) == NS - 1) &&
                 (32'(chan_num) == csb_wrap(32'(lc_q), 1, NCH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0; lcell_q <= '0; lv_q <= 1'b0; run_ok_q <= 1'b0;
    end else if (cell_tick) begin
      lc_q     <= chan_num;
      lcell_q  <= cell_num;
      lv_q     <= 1'b1;
      run_ok_q <= ck_start ? 1'b1 : (run_ok_q & ck_inseq);
    end
  end

  // R1
  always @(posedge clk)
    if (rst_n === 1'b0)
      reset_zero_chk: assert (ctl_out == 1'b0) else $error("output active in reset");

  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_tick |=> $stable(ctl_out));

  // R10
  break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_break |=> !ctl_out);

  // R9
  stale_prefetch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_start && !ck_prev_ok) |=> !ctl_out);
endmodule

bind ctl_flag_serializer csb_checker #(.NS(NS), .NCH(NCH)) u_csb_chk (
  .clk(clk), .rst_n(core_rst_n), .cell_tick(cell_tick),
  .chan_num(chan_num), .cell_num(cell_num), .ctl_out(ctl_out)
);

// File: tb/tb_ctl_flag_serializer.sv
`timescale 1ns/1ps
module tb_ctl_flag_serializer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cell_tick;
  logic [4:0] chan_num;
  logic [2:0] cell_num;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       ctl_out;

  logic [7:0] cmh [256];
  int   q_chan[$], q_cell[$], q_flag[$];
  logic exp_out;
  int   checks = 0, errors = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  ctl_flag_serializer dut (
    .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .chan_num(chan_num),
    .cell_num(cell_num), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctl_out(ctl_out)
  );

  // control memory model: one-clock read latency
  always @(posedge clk) if (rd_en) rd_data <= cmh[rd_addr];

  // per-clock comparison against the reference
  always @(negedge clk) begin
    checks++;
    if (ctl_out !== exp_out) begin
      errors++;
      $display("FAIL %s ctl_out=%0b expected=%0b at %0t", cur_tag, ctl_out, exp_out, $time);
    end
  end

  task automatic fill(input int seed, input logic [7:0] and_m, input logic [7:0] or_m);
    for (int i = 0; i < 256; i++)
      cmh[i] = ((8'(i * 37 + seed * 11) ^ 8'((i >> 3) * 5 + seed)) & and_m) | or_m;
  endtask

  task automatic do_reset();
    #1;
    rst_n = 1'b0; cell_tick = 1'b0; exp_out = 1'b0;
    q_chan.delete(); q_cell.delete(); q_flag.delete();
    repeat (3) @(negedge clk);
    checks++;
    if (rd_en !== 1'b0) begin
      errors++; $display("FAIL R1 rd_en=%0b expected=0 in reset", rd_en);
    end
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_tick(input int c, input int k, input int gap);
    int n, base, ok;
    logic v;
    cell_tick = 1'b1; chan_num = 5'(c); cell_num = 3'(k);
    q_chan.push_back(c); q_cell.push_back(k);
    q_flag.push_back(int'(cmh[k * 32 + (c + 2) % 32][1]));
    while (q_chan.size() > 24) begin
      void'(q_chan.pop_front()); void'(q_cell.pop_front()); void'(q_flag.pop_front());
    end
    n = q_chan.size(); base = n - (9 + k); v = 1'b0;
    if (base >= 0) begin
      ok = 1;
      for (int j = 0; j < 8; j++)
        if (q_chan[base + j] != (c + 31) % 32 || q_cell[base + j] != j) ok = 0;
      for (int j = 0; j <= k; j++)
        if (q_chan[base + 8 + j] != c || q_cell[base + 8 + j] != j) ok = 0;
      if (ok != 0) v = q_flag[base + k][0];
    end
    #1;
    checks++;
    if (rd_en !== 1'b1 || rd_addr !== 8'(k * 32 + (c + 2) % 32)) begin
      errors++;
      $display("FAIL R6 rd_en=%0b rd_addr=%0d expected=1/%0d", rd_en, rd_addr, k * 32 + (c + 2) % 32);
    end
    @(posedge clk);
    exp_out = v;
    @(negedge clk);
    cell_tick = 1'b0;
    #1;
    checks++;
    if (rd_en !== 1'b0) begin
      errors++; $display("FAIL R6 rd_en=%0b expected=0 without tick", rd_en);
    end
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic run_chans(input int start, input int count, input int gap);
    for (int i = 0; i < count; i++)
      for (int k = 0; k < 8; k++) do_tick((start + i) % 32, k, gap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired: run not finished, expected end before 150000 cycles");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cell_tick = 1'b0; chan_num = '0; cell_num = '0; exp_out = 1'b0;
    rd_data = '0;
    fill(1, 8'hFF, 8'h00);
    cur_tag = "R1";
    @(negedge clk);
    do_reset();

    cur_tag = "R3 R4 R7";
    run_chans(0, 70, 2);

    cur_tag = "R2 bits-other-than-1";
    fill(3, 8'hFD, 8'h00);
    run_chans(6, 34, 2);
    cur_tag = "R2 flag-only";
    fill(5, 8'h02, 8'h02);
    run_chans(8, 34, 2);

    cur_tag = "R5 spacing";
    fill(7, 8'hFF, 8'h00);
    run_chans(10, 34, 3);
    for (int i = 0; i < 20; i++)
      for (int k = 0; k < 8; k++) do_tick((12 + i) % 32, k, (k % 2 == 0) ? 2 : 4);

    cur_tag = "R8";
    fill(9, 8'hFF, 8'h00);
    run_chans(0, 10, 2);
    for (int s = 0; s < 8; s++) begin
      cmh[s * 32 + 11] = ~cmh[s * 32 + 11];
      cmh[s * 32 + 12] = ~cmh[s * 32 + 12];
    end
    run_chans(10, 40, 2);

    cur_tag = "R9 realign";
    run_chans(20, 3, 2);
    cur_tag = "R10 dropped cells";
    do_tick(23, 0, 2); do_tick(23, 1, 2); do_tick(23, 2, 2);
    do_tick(23, 5, 2); do_tick(23, 6, 2); do_tick(23, 7, 2);
    cur_tag = "R9 after broken channel";
    run_chans(24, 2, 2);
    cur_tag = "R9 repeated cell0";
    do_tick(26, 0, 2);
    for (int k = 0; k < 8; k++) do_tick(26, k, 2);
    run_chans(27, 2, 2);
    cur_tag = "R3 wrap";
    run_chans(30, 5, 2);

    cur_tag = "R1 mid-run";
    do_reset();
    cur_tag = "R1 R9 resume";
    run_chans(5, 4, 2);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule